// File: doc/BRIEF.md
# Receive Interrupt Request Logic

This block produces the receive interrupt request for one serial channel. It keeps a buffer-full flag and a sticky overrun error flag, and it raises a latched request bit whenever the buffer-full flag goes from empty to holding data. A received-word strobe from the shifter sets the buffer-full flag. A buffer-read strobe from the bus side clears it. A word that arrives while the buffer already holds unread data is an overrun.

A three-bit mode field sets how an overrun is treated. In the I2C-style mode, an overrun raises a fresh request. In every other mode the buffer-full flag shows no new edge, so an overrun produces no request. Software clears the request bit by writing 0, for example after a mode change. The interrupt controller can also clear it with an acknowledge pulse.

A source-select bit picks what drives a shared interrupt vector line: either this channel's request or an alternate peripheral's request.

Top module: `rx_irq_top`

## Requirements
- R1: A cycle with `wordIn` high makes `bufFull` 1 after the next clock edge, whatever its previous value.
- R2: A cycle with `bufRead` high and `wordIn` low makes `bufFull` 0 after the next edge. If both strobes are high in the same cycle, `bufFull` is 1 after the edge.
- R3: When `bufFull` changes from 0 to 1, `irqReq` becomes 1 on the following clock edge, two edges after the `wordIn` strobe. This happens once per transition: while `bufFull` stays 1, a cleared `irqReq` stays 0.
- R4: An overrun is a `wordIn` strobe while `bufFull` is 1 and `bufRead` is low. It makes `ovrErr` 1 after the next edge, and `bufFull` stays 1.
- R5: When `modeSel` is not 3'b010, an overrun leaves `irqReq` unchanged.
- R6: When `modeSel` equals 3'b010 at the overrun, `irqReq` is 1 two edges after the overrun strobe.
- R7: Once set, `ovrErr` stays 1 until a cycle with `ovrClr` high. That cycle makes it 0 after the edge.
- R8: `irqReq` is cleared by a cycle with `irqWrEn`=1 and `irqWrData`=0, or by a cycle with `irqAck`=1. A write with `irqWrData`=1 has no effect on `irqReq`.
- R9: If a hardware set of `irqReq` and a clear (write of 0 or acknowledge) occur on the same edge, `irqReq` is 1 after it.
- R10: `sharedReq` follows `irqReq` when `srcSel` is 0, and follows `altReq` when `srcSel` is 1. The output is combinational.
- R11: A clock edge with `rst` high (synchronous, active high) makes `bufFull`, `ovrErr` and `irqReq` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wordIn | input | 1 | Received-word strobe from the shifter |
| bufRead | input | 1 | Receive-buffer read strobe |
| modeSel | input | 3 | Channel mode field; 3'b010 selects I2C-style mode |
| irqWrEn | input | 1 | Software write strobe for the request bit |
| irqWrData | input | 1 | Value written to the request bit (only 0 acts) |
| irqAck | input | 1 | Acknowledge pulse that clears the request |
| ovrClr | input | 1 | Clear strobe for the overrun flag |
| srcSel | input | 1 | Shared-vector source select (0 = this channel) |
| altReq | input | 1 | Request from the alternate peripheral |
| bufFull | output | 1 | Receive buffer holds unread data |
| ovrErr | output | 1 | Sticky overrun error flag |
| irqReq | output | 1 | Latched receive interrupt request |
| sharedReq | output | 1 | Request driven onto the shared vector |

## Verification
The hardest case to reach is a hardware set and a clear that land on the same edge. The set comes from an edge-detect register one cycle after the buffer-full flag rises. The bench therefore issues the word strobe, then asserts the acknowledge exactly one cycle later, so that both reach the request bit together. The overrun cases are similar. The bench first fills the buffer and clears the pending request, then sends a second word. In the default mode it checks that the request stays 0; in the I2C-style mode it checks that the request appears two edges later.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_I2C = 3'b010;

  // Strobes from the control module to the flag datapath, valid for one cycle
  typedef struct packed {
    logic fullSet;
    logic fullClr;
    logic ovrSet;
    logic ovrClr;
    logic irqSet;
    logic irqClr;
  } rxStrobes_t;

endpackage

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_irq_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter logic [MW-1:0] I2C_CODE = MODE_I2C
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wordIn,
  input  logic          bufRead,
  input  logic [MW-1:0] modeSel,
  input  logic          irqWrEn,
  input  logic          irqWrData,
  input  logic          irqAck,
  input  logic          ovrClr,
  input  logic          bufFull,
  output rxStrobes_t    strobes
);

  logic isI2c;
  logic ovrHit;
  logic prevFull;
  logic ovrHitQ;
  logic fullRise;

  assign isI2c  = (modeSel == I2C_CODE);
  // a read in the same cycle frees the slot, so that case is not an overrun
  assign ovrHit = wordIn && bufFull && !bufRead;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevFull <= 1'b0;
      ovrHitQ  <= 1'b0;
    end else begin
      prevFull <= bufFull;
      ovrHitQ  <= ovrHit && isI2c;
    end
  end

  assign fullRise = bufFull && !prevFull;

  always_comb begin
    strobes         = '0;
    strobes.fullSet = wordIn;
    strobes.fullClr = bufRead && !wordIn;
    strobes.ovrSet  = ovrHit;
    strobes.ovrClr  = ovrClr;
    strobes.irqSet  = fullRise || ovrHitQ;
    strobes.irqClr  = irqAck || (irqWrEn && !irqWrData);
  end

  // R3: the edge detector produces a single-cycle set per rising transition
  assert_rise_single_R3: assert property (@(posedge clk) disable iff (rst)
    fullRise |=> !fullRise);

endmodule

// File: rtl/rx_irq_data.sv
module rx_irq_data
  import rx_irq_pkg::*;
#(
  parameter logic UART_SEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  rxStrobes_t strobes,
  input  logic       srcSel,
  input  logic       altReq,
  output logic       bufFull,
  output logic       ovrErr,
  output logic       irqReq,
  output logic       sharedReq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bufFull <= 1'b0;
    end else if (strobes.fullSet) begin
      bufFull <= 1'b1;
    end else if (strobes.fullClr) begin
      bufFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovrErr <= 1'b0;
    end else if (strobes.ovrClr) begin
      ovrErr <= 1'b0;
    end else if (strobes.ovrSet) begin
      ovrErr <= 1'b1;
    end
  end

  // set dominates clear
  always_ff @(posedge clk) begin
    if (rst) begin
      irqReq <= 1'b0;
    end else if (strobes.irqSet) begin
      irqReq <= 1'b1;
    end else if (strobes.irqClr) begin
      irqReq <= 1'b0;
    end
  end

  generate
    if (UART_SEL == 1'b0) begin : g_selLow
      assign sharedReq = srcSel ? altReq : irqReq;
    end else begin : g_selHigh
      assign sharedReq = srcSel ? irqReq : altReq;
    end
  endgenerate

  // R9: a set always wins over a simultaneous clear
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (strobes.irqSet && strobes.irqClr) |=> irqReq);

  // R7: overrun flag holds without a clear strobe
  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovrErr && !strobes.ovrClr) |=> ovrErr);

endmodule

// File: rtl/rx_irq_top.sv
module rx_irq_top
  import rx_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wordIn,
  input  logic              bufRead,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              irqWrEn,
  input  logic              irqWrData,
  input  logic              irqAck,
  input  logic              ovrClr,
  input  logic              srcSel,
  input  logic              altReq,
  output logic              bufFull,
  output logic              ovrErr,
  output logic              irqReq,
  output logic              sharedReq
);

  rxStrobes_t strobes;

  rx_irq_ctrl #(.MW(MODE_W), .I2C_CODE(MODE_I2C)) u_ctrl (
    .clk(clk), .rst(rst), .wordIn(wordIn), .bufRead(bufRead),
    .modeSel(modeSel), .irqWrEn(irqWrEn), .irqWrData(irqWrData),
    .irqAck(irqAck), .ovrClr(ovrClr), .bufFull(bufFull), .strobes(strobes)
  );

  rx_irq_data #(.UART_SEL(1'b0)) u_data (
    .clk(clk), .rst(rst), .strobes(strobes), .srcSel(srcSel),
    .altReq(altReq), .bufFull(bufFull), .ovrErr(ovrErr),
    .irqReq(irqReq), .sharedReq(sharedReq)
  );

  assert_word_fills_R1: assert property (@(posedge clk) disable iff (rst)
    wordIn |=> bufFull);

  assert_read_empties_R2: assert property (@(posedge clk) disable iff (rst)
    (bufRead && !wordIn) |=> !bufFull);

  assert_rise_raises_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bufFull) |=> irqReq);

  assert_ovr_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (wordIn && bufFull && !bufRead && !ovrClr) |=> (ovrErr && bufFull));

  assert_i2c_ovr_req_R6: assert property (@(posedge clk) disable iff (rst)
    (wordIn && bufFull && !bufRead && modeSel == MODE_I2C) |=> ##1 irqReq);

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (!bufFull && !ovrErr && !irqReq));

endmodule

// File: tb/rx_irq_top_test.sv
module rx_irq_top_test;

  logic clk = 1'b0;
  logic rst, wordIn, bufRead, irqWrEn, irqWrData, irqAck, ovrClr, srcSel, altReq;
  logic [2:0] modeSel;
  logic bufFull, ovrErr, irqReq, sharedReq;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  rx_irq_top uut (
    .clk(clk), .rst(rst), .wordIn(wordIn), .bufRead(bufRead),
    .modeSel(modeSel), .irqWrEn(irqWrEn), .irqWrData(irqWrData),
    .irqAck(irqAck), .ovrClr(ovrClr), .srcSel(srcSel), .altReq(altReq),
    .bufFull(bufFull), .ovrErr(ovrErr), .irqReq(irqReq), .sharedReq(sharedReq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1; wordIn = 0; bufRead = 0; irqWrEn = 0; irqWrData = 0;
    irqAck = 0; ovrClr = 0; srcSel = 0; altReq = 0; modeSel = 3'b000;
    idle(2);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic pulseWord();
    wordIn = 1'b1; @(negedge clk); wordIn = 1'b0;
  endtask

  task automatic swClear();
    irqWrEn = 1'b1; irqWrData = 1'b0; @(negedge clk); irqWrEn = 1'b0;
  endtask

  task automatic testReset();
    pulseWord(); pulseWord(); idle(2);
    doReset();
    chk("R11 bufFull", bufFull, 1'b0);
    chk("R11 ovrErr", ovrErr, 1'b0);
    chk("R11 irqReq", irqReq, 1'b0);
  endtask

  task automatic testFillAndRequest();
    doReset();
    pulseWord();
    chk("R1 bufFull set", bufFull, 1'b1);
    chk("R3 irqReq not yet", irqReq, 1'b0);
    idle(1);
    chk("R3 irqReq raised", irqReq, 1'b1);
    swClear();
    chk("R8 write0 clears", irqReq, 1'b0);
    idle(3);
    chk("R3 single request", irqReq, 1'b0);
  endtask

  task automatic testRead();
    doReset();
    pulseWord(); idle(1);
    bufRead = 1'b1; @(negedge clk); bufRead = 1'b0;
    chk("R2 read clears", bufFull, 1'b0);
    pulseWord(); idle(1);
    bufRead = 1'b1; wordIn = 1'b1; @(negedge clk); bufRead = 1'b0; wordIn = 1'b0;
    chk("R2 word beats read", bufFull, 1'b1);
    chk("R4 no overrun with read", ovrErr, 1'b0);
  endtask

  task automatic testOverrunNormal();
    doReset();
    modeSel = 3'b001;
    pulseWord(); idle(1); swClear();
    pulseWord();
    chk("R4 ovrErr set", ovrErr, 1'b1);
    chk("R4 bufFull held", bufFull, 1'b1);
    idle(3);
    chk("R5 no request", irqReq, 1'b0);
    idle(2);
    chk("R7 ovrErr sticky", ovrErr, 1'b1);
    ovrClr = 1'b1; @(negedge clk); ovrClr = 1'b0;
    chk("R7 ovrErr cleared", ovrErr, 1'b0);
  endtask

  task automatic testOverrunI2c();
    doReset();
    modeSel = 3'b010;
    pulseWord(); idle(1); swClear();
    chk("R6 precondition", irqReq, 1'b0);
    pulseWord();
    chk("R6 one edge", irqReq, 1'b0);
    idle(1);
    chk("R6 request on overrun", irqReq, 1'b1);
  endtask

  task automatic testClearPaths();
    doReset();
    pulseWord(); idle(1);
    irqWrEn = 1'b1; irqWrData = 1'b1; @(negedge clk); irqWrEn = 1'b0;
    chk("R8 write1 no effect", irqReq, 1'b1);
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    chk("R8 ack clears", irqReq, 1'b0);
    irqWrEn = 1'b1; irqWrData = 1'b1; @(negedge clk); irqWrEn = 1'b0;
    chk("R8 write1 does not set", irqReq, 1'b0);
  endtask

  task automatic testSetWins();
    doReset();
    pulseWord();
    irqAck = 1'b1; @(negedge clk); irqAck = 1'b0;
    chk("R9 set beats ack", irqReq, 1'b1);
    swClear();
    bufRead = 1'b1; @(negedge clk); bufRead = 1'b0;
    pulseWord();
    irqWrEn = 1'b1; irqWrData = 1'b0; @(negedge clk); irqWrEn = 1'b0;
    chk("R9 set beats write0", irqReq, 1'b1);
  endtask

  task automatic testMux();
    doReset();
    srcSel = 1'b0; altReq = 1'b1; #1;
    chk("R10 sel0 idle", sharedReq, 1'b0);
    pulseWord(); idle(1);
    chk("R10 sel0 follows req", sharedReq, 1'b1);
    srcSel = 1'b1; altReq = 1'b0; #1;
    chk("R10 sel1 alt low", sharedReq, 1'b0);
    altReq = 1'b1; #1;
    chk("R10 sel1 alt high", sharedReq, 1'b1);
  endtask

  initial begin
    fork
      begin
        testReset();
        testFillAndRequest();
        testRead();
        testOverrunNormal();
        testOverrunI2c();
        testClearPaths();
        testSetWins();
        testMux();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule